// File: doc/BRIEF.md
# USB Device Address Staging Register

This block keeps the bus address of a USB function and tells the packet engine whether the address field of an incoming token belongs to this function. Software reaches it through a plain 32-bit register port with a write strobe, write data and read data. The packet engine reports three kinds of events, each as a one-cycle pulse: an acknowledged IN handshake on endpoint 0, an OUT or SETUP token on endpoint 0, and a bus reset.

The block supports a deferred update. Software can write the new address while the control transfer that assigns it is still running. The value waits in a hidden holding register and becomes the active address only when the IN handshake of the status stage is acknowledged. Any other endpoint 0 traffic cancels the pending update, and so does a reset.

A read returns the active address and the deferred-update flag. The held value is never visible. The match output is combinational on the token address. While the function still has the default address of zero, it accepts every token.

Top module: `usb_devaddr_stage`

## Requirements
- R1: Read data carries the active address in bits 31:25 and the deferred-update flag in bit 24. Bits 23:0 always read as zero, whatever was written to them.
- R2: A controller reset (`rst`) or a bus reset pulse (`bus_rst_evt`) sets the active address to 0 and clears the flag. The result is visible on read data one clock after the pulse.
- R3: While the active address is 0, `addr_match` is 1 for every value of `tok_addr`.
- R4: While the active address is nonzero, `addr_match` is 1 exactly when `tok_addr` equals the active address. The output follows `tok_addr` in the same cycle.
- R5: A write with bit 24 at 0 makes bits 31:25 the active address on the next clock and leaves the flag at 0.
- R6: A write with bit 24 at 1 sets the flag and places bits 31:25 in the holding register. The active address stays unchanged.
- R7: An endpoint 0 IN acknowledge pulse while the flag is set copies the held value into the active address and clears the flag. The same pulse with the flag clear changes nothing.
- R8: An endpoint 0 OUT/SETUP pulse while the flag is set clears the flag and leaves the active address unchanged. A later IN acknowledge then has no effect.
- R9: A bus reset pulse in the same cycle as an endpoint 0 event or a write takes priority over them. The active address becomes 0 and the flag 0.
- R10: Every write loads the holding register, so the held value is always the most recently written address. A write in the same cycle as an endpoint 0 event is applied on top of the outcome of that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data: active address and flag |
| ep0_in_ack_evt | input | 1 | Pulse: IN handshake acknowledged on endpoint 0 |
| ep0_out_setup_evt | input | 1 | Pulse: OUT or SETUP token on endpoint 0 |
| bus_rst_evt | input | 1 | Pulse: USB bus reset seen |
| tok_addr | input | 7 | Address field of the incoming token |
| addr_match | output | 1 | Token is addressed to this function |

## Verification
Random sequences mix immediate writes, staged writes and the three event pulses at low density, so that staging, commit and cancel occur in many different orders.

Directed runs cover the following cases, and each one tells a particular wrong ordering apart from the correct one:
- A staged write followed by an acknowledge distinguishes a deferred update from an immediate one.
- A staged write, then a SETUP, then an acknowledge shows whether the cancel really drops the pending value.
- A reset coinciding with an acknowledge shows which of the two wins.
- A write coinciding with an acknowledge shows which of the two wins.

The token address is drawn half of the time equal to the active address and half of the time at random. This separates the accept-all behaviour at address zero from exact comparison.

// File: rtl/usbaddr_pkg.sv
package usbaddr_pkg;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_ADDR_W   = 7;
  localparam int unsigned DEF_ADDR_LSB = 25;
  localparam int unsigned DEF_FLAG_BIT = 24;

  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_RESET  = 2'd1,
    UPD_COMMIT = 2'd2,
    UPD_CANCEL = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/usbaddr_event_arb.sv
module usbaddr_event_arb
  import usbaddr_pkg::*;
(
  input  logic      bus_rst,
  input  logic      in_ack,
  input  logic      out_setup,
  input  logic      flag_q,
  output upd_kind_e kind
);
  always_comb begin
    kind = UPD_NONE;
    if (bus_rst) begin
      kind = UPD_RESET;
    end else if (flag_q && in_ack) begin
      kind = UPD_COMMIT;
    end else if (flag_q && out_setup) begin
      kind = UPD_CANCEL;
    end
  end
endmodule

// File: rtl/usbaddr_stage_regs.sv
module usbaddr_stage_regs
  import usbaddr_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_kind_e         kind,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] act_q,
  output logic              flag_q
);
  logic [ADDR_W-1:0] hold_q;
  logic [ADDR_W-1:0] act_n;
  logic [ADDR_W-1:0] hold_n;
  logic              flag_n;

  always_comb begin
    act_n  = act_q;
    hold_n = hold_q;
    flag_n = flag_q;
    unique case (kind)
      UPD_RESET: begin
        act_n  = '0;
        hold_n = '0;
        flag_n = 1'b0;
      end
      UPD_COMMIT: begin
        act_n  = hold_q;
        flag_n = 1'b0;
      end
      UPD_CANCEL: flag_n = 1'b0;
      default: ;
    endcase
    if (wr_en && (kind != UPD_RESET)) begin
      hold_n = wr_addr;
      if (wr_flag) begin
        flag_n = 1'b1;
      end else begin
        act_n  = wr_addr;
        flag_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      hold_q <= hold_n;
      flag_q <= flag_n;
    end
  end
endmodule

// File: rtl/usbaddr_match.sv
module usbaddr_match #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              hit
);
  logic is_default;
  assign is_default = (act_addr == '0);
  assign hit        = is_default || (tok_addr == act_addr);
endmodule

// File: rtl/usbaddr_regmap.sv
module usbaddr_regmap #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned ADDR_LSB = 25,
  parameter int unsigned FLAG_BIT = 24
) (
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic              flag,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_flag,
  output logic [DATA_W-1:0] rdata
);
  assign wr_addr = wdata[ADDR_LSB +: ADDR_W];
  assign wr_flag = wdata[FLAG_BIT];

  always_comb begin
    rdata                       = '0;
    rdata[ADDR_LSB +: ADDR_W]   = act_addr;
    rdata[FLAG_BIT]             = flag;
  end
endmodule

// File: rtl/usb_devaddr_stage.sv
module usb_devaddr_stage
  import usbaddr_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned ADDR_LSB = DEF_ADDR_LSB,
  parameter int unsigned FLAG_BIT = DEF_FLAG_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ep0_in_ack_evt,
  input  logic              ep0_out_setup_evt,
  input  logic              bus_rst_evt,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              addr_match
);
  upd_kind_e         kind;
  logic [ADDR_W-1:0] act_q;
  logic              flag_q;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_flag;

  usbaddr_event_arb u_arb (
    .bus_rst   (bus_rst_evt),
    .in_ack    (ep0_in_ack_evt),
    .out_setup (ep0_out_setup_evt),
    .flag_q    (flag_q),
    .kind      (kind)
  );

  usbaddr_regmap #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ADDR_LSB (ADDR_LSB),
    .FLAG_BIT (FLAG_BIT)
  ) u_map (
    .wdata    (reg_wdata),
    .act_addr (act_q),
    .flag     (flag_q),
    .wr_addr  (wr_addr),
    .wr_flag  (wr_flag),
    .rdata    (reg_rdata)
  );

  usbaddr_stage_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .wr_en   (reg_we),
    .wr_flag (wr_flag),
    .wr_addr (wr_addr),
    .act_q   (act_q),
    .flag_q  (flag_q)
  );

  usbaddr_match #(
    .ADDR_W (ADDR_W)
  ) u_match (
    .act_addr (act_q),
    .tok_addr (tok_addr),
    .hit      (addr_match)
  );
endmodule

// File: rtl/usbaddr_chk.sv
module usbaddr_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned ADDR_LSB = 25,
  parameter int unsigned FLAG_BIT = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ep0_in_ack_evt,
  input logic              ep0_out_setup_evt,
  input logic              bus_rst_evt,
  input logic [ADDR_W-1:0] tok_addr,
  input logic              addr_match
);
  logic [ADDR_W-1:0] r_act;
  logic              r_flag;
  assign r_act  = reg_rdata[ADDR_LSB +: ADDR_W];
  assign r_flag = reg_rdata[FLAG_BIT];

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[FLAG_BIT-1:0] == '0);

  assert_busrst_clears_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rst_evt |=> (r_act == '0) && !r_flag);

  assert_default_accepts_R3: assert property (@(posedge clk) disable iff (rst)
    (r_act == '0) |-> addr_match);

  assert_nonzero_compare_R4: assert property (@(posedge clk) disable iff (rst)
    (r_act != '0) && (tok_addr != r_act) |-> !addr_match);

  assert_direct_write_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we && !reg_wdata[FLAG_BIT] && !bus_rst_evt
    |=> (r_act == $past(reg_wdata[ADDR_LSB +: ADDR_W])) && !r_flag);

  assert_staged_write_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_wdata[FLAG_BIT] && !bus_rst_evt && !(ep0_in_ack_evt && r_flag)
    |=> r_flag && $stable(r_act));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    ep0_in_ack_evt && r_flag && !reg_we |=> !r_flag);

  assert_cancel_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    ep0_out_setup_evt && !ep0_in_ack_evt && r_flag && !reg_we && !bus_rst_evt
    |=> !r_flag && $stable(r_act));

  assert_reset_priority_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rst_evt && (ep0_in_ack_evt || reg_we) |=> (r_act == '0));
endmodule

bind usb_devaddr_stage usbaddr_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .ADDR_LSB (ADDR_LSB),
  .FLAG_BIT (FLAG_BIT)
) u_chk (
  .clk               (clk),
  .rst               (rst),
  .reg_we            (reg_we),
  .reg_wdata         (reg_wdata),
  .reg_rdata         (reg_rdata),
  .ep0_in_ack_evt    (ep0_in_ack_evt),
  .ep0_out_setup_evt (ep0_out_setup_evt),
  .bus_rst_evt       (bus_rst_evt),
  .tok_addr          (tok_addr),
  .addr_match        (addr_match)
);

// File: tb/usb_devaddr_stage_tb_top.sv
`timescale 1ns/1ps
module usb_devaddr_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ep0_in_ack_evt;
  logic        ep0_out_setup_evt;
  logic        bus_rst_evt;
  logic [6:0]  tok_addr;
  logic        addr_match;

  int checks = 0;
  int bad    = 0;

  logic [6:0] m_act;
  logic [6:0] m_hold;
  logic       m_flag;

  always #4 clk = ~clk;

  usb_devaddr_stage dut_i (
    .clk               (clk),
    .rst               (rst),
    .reg_we            (reg_we),
    .reg_wdata         (reg_wdata),
    .reg_rdata         (reg_rdata),
    .ep0_in_ack_evt    (ep0_in_ack_evt),
    .ep0_out_setup_evt (ep0_out_setup_evt),
    .bus_rst_evt       (bus_rst_evt),
    .tok_addr          (tok_addr),
    .addr_match        (addr_match)
  );

  function automatic logic exp_match(input logic [6:0] act, input logic [6:0] tok);
    return (act == 7'd0) || (act == tok);
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [6:0] act, input logic flag);
    return {act, flag, 24'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic model_update(input logic r, input logic we, input logic [31:0] wd,
                              input logic ack, input logic cxl, input logic brst);
    if (r || brst) begin
      m_act = 0; m_hold = 0; m_flag = 0;
    end else begin
      if (m_flag && ack) begin
        m_act = m_hold; m_flag = 0;
      end else if (m_flag && cxl) begin
        m_flag = 0;
      end
      if (we) begin
        m_hold = wd[31:25];
        if (wd[24]) m_flag = 1;
        else begin m_act = wd[31:25]; m_flag = 0; end
      end
    end
  endtask

  // Runs one cycle: drive at negedge, check match, clock, check readback.
  task automatic step(input logic r, input logic we, input logic [31:0] wd,
                      input logic ack, input logic cxl, input logic brst,
                      input logic [6:0] tok);
    string tag;
    rst = r; reg_we = we; reg_wdata = wd;
    ep0_in_ack_evt = ack; ep0_out_setup_evt = cxl; bus_rst_evt = brst;
    tok_addr = tok;
    #1;
    if (!r) check((m_act == 0) ? "R3" : "R4", {31'd0, addr_match},
                  {31'd0, exp_match(m_act, tok)});
    if (brst && (ack || cxl || we)) tag = "R9";
    else if (r || brst)             tag = "R2";
    else if (we && (ack || cxl))    tag = "R10";
    else if (we && wd[24])          tag = "R6";
    else if (we)                    tag = "R5";
    else if (ack)                   tag = "R7";
    else if (cxl)                   tag = "R8";
    else                            tag = "R1";
    @(posedge clk);
    model_update(r, we, wd, ack, cxl, brst);
    @(negedge clk);
    check(tag, reg_rdata, exp_rdata(m_act, m_flag));
  endtask

  function automatic logic [31:0] wr(input logic [6:0] a, input logic f, input logic [23:0] junk);
    return {a, f, junk};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    m_act = 0; m_hold = 0; m_flag = 0;
    rst = 1; reg_we = 0; reg_wdata = 0; ep0_in_ack_evt = 0;
    ep0_out_setup_evt = 0; bus_rst_evt = 0; tok_addr = 0;
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // R2 reset state, R1 reserved zero even with junk written below
    check("R2", reg_rdata, 32'd0);
    step(0, 0, 0, 0, 0, 0, 7'h55);                          // R3 any token matches
    step(0, 1, wr(7'h12, 0, 24'hFFFFFF), 0, 0, 0, 7'h12);   // R5, R1
    check("R1", {8'd0, reg_rdata[23:0]}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 7'h13);                          // R4 mismatch
    step(0, 1, wr(7'h2A, 1, 0), 0, 0, 0, 7'h12);            // R6 staged
    step(0, 0, 0, 1, 0, 0, 7'h2A);                          // R7 commit
    step(0, 0, 0, 1, 0, 0, 7'h2A);                          // R7 no flag
    step(0, 1, wr(7'h33, 1, 0), 0, 0, 0, 0);                // R6
    step(0, 0, 0, 0, 1, 0, 7'h33);                          // R8 cancel
    step(0, 0, 0, 1, 0, 0, 7'h33);                          // R8 ack ignored
    step(0, 1, wr(7'h44, 1, 0), 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1, 7'h44);                          // R9 reset wins
    step(0, 1, wr(7'h05, 1, 0), 0, 0, 0, 0);
    step(0, 1, wr(7'h06, 1, 0), 1, 0, 0, 0);                // R10 commit then restage
    step(0, 0, 0, 1, 0, 0, 7'h06);                          // R7 gets latest value
    step(0, 1, wr(7'h07, 0, 0), 0, 0, 1, 0);                // R9 reset beats write
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] tk;
      tk = ($urandom % 2) ? m_act : 7'($urandom);
      step(($urandom % 97) == 0, ($urandom % 5) == 0,
           {7'($urandom % 8 == 0 ? 0 : $urandom), 1'($urandom), 24'($urandom)},
           ($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 41) == 0, tk);
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule